// File: doc/BRIEF.md
# Video Test Pattern Generator

This block sits in a video pipeline and can substitute the live luma and chroma samples with synthetic levels. With the generator switched off, the incoming Y and C samples are copied to the outputs one clock later. With it switched on, both outputs carry the same synthetic value. That value is either a falling ramp across the line or one of three fixed levels.

A 16-bit control word is written through a simple write strobe and can be read back. The control word holds an enable flag and a two-bit pattern selector; all other bits are reserved. A written setting does not act at once. It is carried over to the video path on the next line-start strobe, so a line is never split between two patterns. The line-start strobe marks the first pixel of a line, and the pixel-valid strobe marks each active pixel. Both strobes come from an external timing source.

Top module: `video_tpg`

## Requirements
- R1: After reset, yOut, cOut and cfgRdata are all zero, and the block is in pass-through with ramp selected.
- R2: While the generator is not in effect, yOut and cOut equal yIn and cIn from the previous clock.
- R3: A write stores bit 11 (enable) and bits 13:12 (pattern selector). cfgRdata returns those bits, and every other bit reads as zero, whatever was written there.
- R4: With selector 00 in effect, the output is 240 on a cycle where lineStart is high. Each valid pixel after that lowers the output by one on the next pixel.
- R5: The ramp never goes below 17. Once it reaches 17, it stays there until the next lineStart.
- R6: A cycle with pixValid low does not move the ramp.
- R7: Selector 01 gives a constant 16 on both outputs.
- R8: Selector 10 gives a constant 90 on both outputs.
- R9: Selector 11 gives a constant 240 on both outputs.
- R10: A new enable or selector value takes effect only from a cycle with lineStart high, and that cycle already uses the new value. Before that cycle, the old setting stays in force.
- R11: While the generator is in effect, yOut equals cOut.
- R12: Outputs are registered. The output after a clock edge reflects the inputs, strobes and setting present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgWdata | input | 16 | Control word write data |
| cfgRdata | output | 16 | Control word readback |
| pixValid | input | 1 | Active pixel strobe |
| lineStart | input | 1 | First pixel of a line |
| yIn | input | 8 | Live luma sample |
| cIn | input | 8 | Live chroma sample |
| yOut | output | 8 | Luma output |
| cOut | output | 8 | Chroma output |

## Verification
The hardest state to reach is the ramp floor. To get there, a single line must carry more than 223 valid pixels without a lineStart. Some of those pixels must arrive after the value has already reached 17, and idle gaps must be mixed in. The stimulus drives one long line of about 260 pixels with gaps placed among them. It writes a new selector part-way through that line. This shows both the hold at 17 and the late switch-over in one pass.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    MODE_RAMP = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_MID  = 2'b10,
    MODE_HIGH = 2'b11
  } tpgModeE;

  typedef struct packed {
    logic    reload;
    logic    step;
    logic    patSel;
    tpgModeE mode;
  } tpgCtlT;
endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int EN_BIT   = 11,
  parameter int MODE_LSB = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             pixValid,
  input  logic             lineStart,
  output tpgCtlT           ctl
);
  localparam int MODE_W = 2;

  logic    regEn, effEn;
  tpgModeE regMode, effMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regEn   <= 1'b0;
      regMode <= MODE_RAMP;
      effEn   <= 1'b0;
      effMode <= MODE_RAMP;
    end else begin
      if (cfgWe) begin
        regEn   <= cfgWdata[EN_BIT];
        regMode <= tpgModeE'(cfgWdata[MODE_LSB +: MODE_W]);
      end
      if (lineStart) begin
        effEn   <= regEn;
        effMode <= regMode;
      end
    end
  end

  always_comb begin
    cfgRdata                      = '0;
    cfgRdata[EN_BIT]              = regEn;
    cfgRdata[MODE_LSB +: MODE_W]  = regMode;
  end

  always_comb begin
    ctl.reload = lineStart;
    ctl.step   = pixValid;
    ctl.patSel = lineStart ? regEn : effEn;
    ctl.mode   = lineStart ? regMode : effMode;
  end

  // R10: the active setting only moves on a line start
  assert_setting_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> ($stable(effEn) && $stable(effMode)));

  // R10: a line start takes over the stored setting
  assert_setting_apply_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !cfgWe) |=> (effEn == regEn && effMode == regMode));
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RAMP_TOP = 240,
  parameter int RAMP_BOT = 17,
  parameter int LVL_LOW  = 16,
  parameter int LVL_MID  = 90,
  parameter int LVL_HIGH = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpgCtlT            ctl,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] cIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut
);
  localparam logic [DATA_W-1:0] TOP_V  = DATA_W'(RAMP_TOP);
  localparam logic [DATA_W-1:0] BOT_V  = DATA_W'(RAMP_BOT);
  localparam logic [DATA_W-1:0] LOW_V  = DATA_W'(LVL_LOW);
  localparam logic [DATA_W-1:0] MID_V  = DATA_W'(LVL_MID);
  localparam logic [DATA_W-1:0] HIGH_V = DATA_W'(LVL_HIGH);

  logic [DATA_W-1:0] rampReg, rampCur, rampNext, patVal;

  always_comb begin
    rampCur  = ctl.reload ? TOP_V : rampReg;
    rampNext = rampCur;
    if (ctl.step) rampNext = (rampCur > BOT_V) ? rampCur - 1'b1 : BOT_V;
  end

  always_comb begin
    unique case (ctl.mode)
      MODE_RAMP: patVal = rampCur;
      MODE_LOW:  patVal = LOW_V;
      MODE_MID:  patVal = MID_V;
      MODE_HIGH: patVal = HIGH_V;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampReg <= TOP_V;
      yOut    <= '0;
      cOut    <= '0;
    end else begin
      rampReg <= rampNext;
      yOut    <= ctl.patSel ? patVal : yIn;
      cOut    <= ctl.patSel ? patVal : cIn;
    end
  end

  assert_ramp_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rampReg >= BOT_V && rampReg <= TOP_V));

  assert_ramp_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rampReg == BOT_V && !ctl.reload) |=> rampReg == BOT_V);

  assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.reload && rampReg > BOT_V) |=> rampReg == $past(rampReg) - 1'b1);

  assert_ramp_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reload && ctl.step) |=> rampReg == TOP_V - 1'b1);

  assert_ramp_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.step && !ctl.reload) |=> $stable(rampReg));

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.patSel |=> (yOut == $past(yIn) && cOut == $past(cIn)));

  assert_yc_equal_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.patSel |=> yOut == cOut);
endmodule

// File: rtl/video_tpg.sv
module video_tpg
  import tpg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  input  logic              pixValid,
  input  logic              lineStart,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] cIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut
);
  tpgCtlT ctl;

  tpg_ctrl #(.CFG_W(CFG_W), .EN_BIT(11), .MODE_LSB(12)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .pixValid(pixValid), .lineStart(lineStart), .ctl(ctl)
  );

  tpg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .yIn(yIn), .cIn(cIn),
    .yOut(yOut), .cOut(cOut)
  );
endmodule

// File: tb/video_tpg_tb.sv
module video_tpg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        pixValid = 1'b0;
  logic        lineStart = 1'b0;
  logic [7:0]  yIn = '0, cIn = '0;
  logic [7:0]  yOut, cOut;

  always #4 clk = ~clk;

  video_tpg u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .pixValid(pixValid), .lineStart(lineStart), .yIn(yIn), .cIn(cIn),
    .yOut(yOut), .cOut(cOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] qy[$];
  logic [7:0] qc[$];
  string      qt[$];

  // reference state derived from the requirements
  bit       mRegEn = 0, mEffEn = 0;
  bit [1:0] mRegMode = 0, mEffMode = 0;
  int       mRamp = 240;
  int       seed = 0;
  bit       monOn = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit pv, input bit ls, input bit we, input logic [15:0] wd,
                       input string tag);
    bit       en;
    bit [1:0] md;
    int       cur, pat;
    logic [7:0] yv, cv;
    @(negedge clk);
    seed++;
    yv = 8'(seed * 37 + 5);
    cv = 8'(seed * 11 + 100);
    pixValid = pv; lineStart = ls; cfgWe = we; cfgWdata = wd; yIn = yv; cIn = cv;
    en  = ls ? mRegEn : mEffEn;
    md  = ls ? mRegMode : mEffMode;
    cur = ls ? 240 : mRamp;
    case (md)
      2'b00: pat = cur;
      2'b01: pat = 16;
      2'b10: pat = 90;
      default: pat = 240;
    endcase
    qy.push_back(en ? 8'(pat) : yv);
    qc.push_back(en ? 8'(pat) : cv);
    qt.push_back(tag);
    if (ls) begin mEffEn = mRegEn; mEffMode = mRegMode; end
    mRamp = pv ? ((cur > 17) ? cur - 1 : 17) : cur;
    if (we) begin mRegEn = wd[11]; mRegMode = wd[13:12]; end
  endtask

  // monitor: compare each registered output against the scoreboard (R12)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (monOn && qy.size() > 0) begin
        logic [7:0] ey, ec;
        string t;
        ey = qy.pop_front(); ec = qc.pop_front(); t = qt.pop_front();
        check(yOut == ey, {t, " R12 yOut"}, yOut, ey);
        check(cOut == ec, {t, " R12 cOut"}, cOut, ec);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(yOut == 8'd0, "R1 yOut at reset", yOut, 0);
    check(cOut == 8'd0, "R1 cOut at reset", cOut, 0);
    check(cfgRdata == 16'd0, "R1 cfgRdata at reset", cfgRdata, 0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // R2: pass-through while disabled, with and without strobes
    for (int i = 0; i < 8; i++) drive(i[0], i == 3, 0, 16'h0, "R2 passthrough");

    // R3/R10: enable ramp; nothing changes before the line start
    drive(1, 0, 1, 16'h0800, "R10 write enable");
    @(posedge clk); #2;
    check(cfgRdata == 16'h0800, "R3 readback enable", cfgRdata, 16'h0800);
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 16'h0, "R10 still passthrough");

    // R4/R5/R6/R11: one long line with gaps, ramp to the floor and hold
    drive(1, 1, 0, 16'h0, "R4 line start 240");
    for (int i = 0; i < 260; i++) begin
      bit pv;
      pv = (i % 7) != 3;
      drive(pv, 0, 0, 16'h0, pv ? "R4 R5 ramp R11" : "R6 gap holds");
    end
    for (int i = 0; i < 5; i++) drive(1, 0, 0, 16'h0, "R5 floor at 17");

    // R10: new selector mid-line has no effect until line start
    drive(1, 0, 1, 16'h1800, "R10 write sel 01");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 16'h0, "R10 old ramp kept");
    drive(1, 1, 0, 16'h0, "R7 level 16");
    for (int i = 0; i < 4; i++) drive(i != 2, 0, 0, 16'h0, "R7 R11 level 16");

    drive(0, 0, 1, 16'h2800, "R8 write sel 10");
    drive(1, 1, 0, 16'h0, "R8 level 90");
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 16'h0, "R8 R11 level 90");

    drive(0, 0, 1, 16'h3800, "R9 write sel 11");
    drive(1, 1, 0, 16'h0, "R9 level 240");
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 16'h0, "R9 R11 level 240");

    // ramp restarts on a fresh line (R4)
    drive(0, 0, 1, 16'h0800, "R4 back to ramp");
    drive(1, 1, 0, 16'h0, "R4 restart 240");
    for (int i = 0; i < 6; i++) drive(1, 0, 0, 16'h0, "R4 ramp restart");

    // disable: pass-through returns only at the line start (R10, R2)
    drive(1, 0, 1, 16'h0000, "R10 write disable");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 16'h0, "R10 pattern kept");
    drive(1, 1, 0, 16'h0, "R2 passthrough again");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 16'h0, "R2 passthrough again");

    // R3: reserved bits are dropped
    drive(0, 0, 1, 16'hFFFF, "R3 write all ones");
    @(posedge clk); #2;
    check(cfgRdata == 16'h3800, "R3 reserved read zero", cfgRdata, 16'h3800);
    drive(1, 1, 0, 16'h0, "R9 all-ones gives 240");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 16'h0, "R9 R11 all-ones");

    repeat (4) @(posedge clk);
    #3;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule